// File: doc/BRIEF.md
# Fixed-Priority Shared Bus Arbiter

This block decides which of several bus masters may drive a shared bus. Each master raises its own request line. The arbiter answers with a registered one-hot grant vector. Priority is fixed by index: master 0 outranks every other master, and rank falls as the index rises. The owner of the bus keeps its request high for the whole transfer and pulses its last-beat line on the final cycle. The arbiter then hands the bus on at the following clock edge.

A mode input sets what happens when a higher-ranked master asks for the bus while a lower-ranked one holds it. With the input high, the newcomer takes the bus at the next edge, even in the middle of the owner's transfer. With the input low, the newcomer waits until the owner finishes. The mode is sampled every cycle, so it can be changed at run time.

The block does not protect low-ranked masters from starvation. A master can wait for as long as higher-ranked masters keep requesting. When nobody requests, no master holds the grant.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While the synchronous active-high reset is sampled high, every grant bit becomes 0 at that clock edge.
- R2: At most one bit of the grant vector is 1 at any time; bit i stands for master i.
- R3: If no request is asserted at a clock edge, the grant vector is all zeros after that edge.
- R4: When no master owns the bus, the grant goes at the next edge to the lowest-index master that is requesting. Index 0 has the highest priority.
- R5: A grant bit is only set after an edge at which the same master's request was high.
- R6: With the mode input low, an owner that keeps requesting and does not assert last keeps its grant, even when a lower-index master requests.
- R7: With the mode input high, a request from any index lower than the owner's moves the grant to the lowest-index requester at the next edge, even mid-transfer.
- R8: When the owner asserts its last bit at an edge, it loses the grant at that edge. The grant passes to the lowest-index requester among the other masters, or to nobody if none requests.
- R9: When the owner drops its request, it loses the grant at that edge, and the grant passes in the same way as in R8.
- R10: A requesting master stays ungranted for as long as a lower-index master keeps owning the bus, for any number of cycles.
- R11: The mode input is evaluated at every edge. Raising it during a transfer lets a waiting higher-priority request preempt at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| preempt_en | input | 1 | 1 = higher-priority requests preempt the owner; 0 = they wait for the transfer to end |
| mst_req | input | NUM_MST | Request line of each master, held high for the whole transfer |
| mst_last | input | NUM_MST | Final-beat marker of each master; only the owner's bit has an effect |
| mst_grant | output | NUM_MST | Registered one-hot grant, all zeros when the bus is idle |

## Verification
The hardest case to reach from the ports is a handover that coincides with a higher-priority arrival or a mode change. Examples are an owner asserting last in the same cycle that a lower-index master requests, or the mode flipping high while a lower-priority owner is mid-transfer. Random stimulus keeps requests sticky, so transfers last several cycles. It pulses last sparsely and toggles the mode only now and then, which makes these overlaps recur. Directed steps first pin down the mode switch, starvation of the lowest-ranked master and the release after a request drop.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Outcome of one arbitration step
    typedef enum logic [1:0] {
        ARB_DEC_IDLE    = 2'd0,  // bus free: grant best requester
        ARB_DEC_HOLD    = 2'd1,  // owner keeps the bus
        ARB_DEC_HANDOFF = 2'd2,  // owner finished or left: pass on
        ARB_DEC_PREEMPT = 2'd3   // higher-priority request steals bus
    } arb_dec_e;

    // Summary of the current owner seen by the decision logic
    typedef struct packed {
        logic present;   // some master holds the grant
        logic still_req; // owner still requesting
        logic at_last;   // owner signals its final beat
        logic outranked; // a lower-index master requests
    } arb_owner_t;

    function automatic logic dec_keeps_owner(arb_dec_e d);
        return (d == ARB_DEC_HOLD);
    endfunction

    function automatic arb_dec_e decide(arb_owner_t o, logic preempt);
        if (!o.present)                  return ARB_DEC_IDLE;
        if (!o.still_req || o.at_last)   return ARB_DEC_HANDOFF;
        if (preempt && o.outranked)      return ARB_DEC_PREEMPT;
        return ARB_DEC_HOLD;
    endfunction

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int NUM_MST = 4
) (
    input  logic [NUM_MST-1:0] cand,
    output logic [NUM_MST-1:0] pick
);
    // seen[i] = some candidate with index below i exists
    logic [NUM_MST-1:0] seen;

    for (genvar i = 0; i < NUM_MST; i++) begin : g_chain
        if (i == 0) begin : g_first
            assign seen[i] = 1'b0;
        end else begin : g_rest
            assign seen[i] = seen[i-1] | cand[i-1];
        end
        assign pick[i] = cand[i] & ~seen[i];
    end

endmodule

// File: rtl/arb_owner_ctrl.sv
module arb_owner_ctrl
    import arb_pkg::*;
#(
    parameter int NUM_MST = 4
) (
    input  logic [NUM_MST-1:0] grant_q,
    input  logic [NUM_MST-1:0] req,
    input  logic [NUM_MST-1:0] last,
    input  logic               preempt_en,
    output arb_dec_e           dec,
    output logic [NUM_MST-1:0] cand
);
    arb_owner_t         own;
    logic [NUM_MST-1:0] above_mask; // indices ranked above the owner

    always_comb begin
        above_mask      = grant_q - 1'b1;
        own.present     = |grant_q;
        own.still_req   = |(grant_q & req);
        own.at_last     = |(grant_q & last);
        own.outranked   = own.present && (|(req & above_mask));
        dec             = decide(own, preempt_en);
        unique case (dec)
            ARB_DEC_IDLE:    cand = req;
            ARB_DEC_HANDOFF: cand = req & ~grant_q;
            ARB_DEC_PREEMPT: cand = req & above_mask;
            default:         cand = '0;
        endcase
    end

endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_MST = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               preempt_en,
    input  logic [NUM_MST-1:0] mst_req,
    input  logic [NUM_MST-1:0] mst_last,
    output logic [NUM_MST-1:0] mst_grant
);
    arb_dec_e           dec;
    logic [NUM_MST-1:0] cand;
    logic [NUM_MST-1:0] pick;
    logic [NUM_MST-1:0] grant_q;
    logic [NUM_MST-1:0] grant_d;

    arb_owner_ctrl #(.NUM_MST(NUM_MST)) ctrl_i (
        .grant_q    (grant_q),
        .req        (mst_req),
        .last       (mst_last),
        .preempt_en (preempt_en),
        .dec        (dec),
        .cand       (cand)
    );

    arb_prio_pick #(.NUM_MST(NUM_MST)) pick_i (
        .cand (cand),
        .pick (pick)
    );

    always_comb begin
        grant_d = dec_keeps_owner(dec) ? grant_q : pick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
        end else begin
            grant_q <= grant_d;
        end
    end

    assign mst_grant = grant_q;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int NUM_MST = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               preempt_en,
    input logic [NUM_MST-1:0] mst_req,
    input logic [NUM_MST-1:0] mst_last,
    input logic [NUM_MST-1:0] mst_grant
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (mst_grant == '0));

    assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mst_grant));

    assert_idle_when_no_req_R3: assert property (@(posedge clk) disable iff (rst)
        (mst_req == '0) |=> (mst_grant == '0));

    assert_idle_picks_best_R4: assert property (@(posedge clk) disable iff (rst)
        ((mst_grant == '0) && (mst_req != '0)) |=>
        ((mst_grant != '0) && (((mst_grant - 1'b1) & $past(mst_req)) == '0)));

    assert_grant_needs_req_R5: assert property (@(posedge clk) disable iff (rst)
        (mst_grant != '0) |=> ((mst_grant & ~$past(mst_req)) == '0));

    assert_hold_nonpreempt_R6: assert property (@(posedge clk) disable iff (rst)
        (!preempt_en && ((mst_grant & mst_req) != '0) && ((mst_grant & mst_last) == '0))
        |=> (mst_grant == $past(mst_grant)));

    assert_preempt_takes_R7: assert property (@(posedge clk) disable iff (rst)
        (preempt_en && ((mst_grant & mst_req) != '0) && ((mst_req & (mst_grant - 1'b1)) != '0))
        |=> ((mst_grant != '0) && (mst_grant < $past(mst_grant))));

    assert_release_on_last_R8: assert property (@(posedge clk) disable iff (rst)
        ((mst_grant & mst_last) != '0) |=> ((mst_grant & $past(mst_grant)) == '0));

    assert_release_on_drop_R9: assert property (@(posedge clk) disable iff (rst)
        ((mst_grant != '0) && ((mst_grant & mst_req) == '0))
        |=> ((mst_grant & $past(mst_grant)) == '0));

endmodule

bind prio_bus_arbiter arb_checker #(.NUM_MST(NUM_MST)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .preempt_en (preempt_en),
    .mst_req    (mst_req),
    .mst_last   (mst_last),
    .mst_grant  (mst_grant)
);

// File: tb/prio_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module prio_bus_arbiter_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] lst = '0;
    logic [N-1:0] grant;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] exp_g = '0;

    always #2 clk = ~clk;

    prio_bus_arbiter #(.NUM_MST(N)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .preempt_en (mode),
        .mst_req    (req),
        .mst_last   (lst),
        .mst_grant  (grant)
    );

    // lowest-index set bit of v
    function automatic logic [N-1:0] best(logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return (N'(1) << i);
        return '0;
    endfunction

    // expected grant after one edge, from the requirements
    function automatic logic [N-1:0] expect_next(logic [N-1:0] g, logic [N-1:0] r,
                                                 logic [N-1:0] l, logic m);
        if (g == '0) return best(r);                          // R4 / R3
        if ((g & r) == '0 || (g & l) != '0) return best(r & ~g); // R8 / R9
        if (m && best(r) != g) return best(r);                // R7 / R11
        return g;                                             // R6 / R10
    endfunction

    function automatic string tag_of(logic [N-1:0] g, logic [N-1:0] r,
                                     logic [N-1:0] l, logic m);
        if (r == '0) return "R3";
        if (g == '0) return "R4";
        if ((g & l) != '0) return "R8";
        if ((g & r) == '0) return "R9";
        if (m && best(r) != g) return "R7";
        return "R6";
    endfunction

    task automatic check(input logic [N-1:0] expv, input string tag);
        checks++;
        if (grant !== expv) begin
            errors++;
            $display("FAIL %s: grant=%b expected=%b", tag, grant, expv);
        end
        checks++;
        if ($countones(grant) > 1) begin
            errors++;
            $display("FAIL R2: grant=%b expected at most one bit", grant);
        end
    endtask

    // drive at negedge, sample 1 ns after the next rising edge
    task automatic step(input logic [N-1:0] r, input logic [N-1:0] l, input logic m,
                        input logic [N-1:0] expv, input string tag);
        @(negedge clk);
        req = r; lst = l; mode = m;
        @(posedge clk);
        #1;
        check(expv, tag);
        exp_g = expv;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset clears grant, even with requests pending
        rst = 1'b1; req = 4'b1111;
        repeat (3) @(posedge clk);
        #1; check(4'b0000, "R1");
        @(negedge clk); rst = 1'b0;

        step(4'b0000, 4'b0000, 1'b0, 4'b0000, "R3");
        step(4'b1010, 4'b0000, 1'b0, 4'b0010, "R4");
        step(4'b1011, 4'b0000, 1'b0, 4'b0010, "R6");
        step(4'b1011, 4'b0010, 1'b0, 4'b0001, "R8");
        // R10: master 3 waits while master 0 keeps the bus
        for (int k = 0; k < 6; k++) step(4'b1001, 4'b0000, 1'b0, 4'b0001, "R10");
        step(4'b1000, 4'b0000, 1'b0, 4'b1000, "R9");
        step(4'b1100, 4'b0000, 1'b1, 4'b0100, "R7");
        step(4'b0110, 4'b0000, 1'b0, 4'b0100, "R6");
        step(4'b0110, 4'b0000, 1'b1, 4'b0010, "R11");
        // R8: last from owner while the same master re-requests
        step(4'b0010, 4'b0010, 1'b0, 4'b0000, "R8");
        step(4'b0000, 4'b0000, 1'b1, 4'b0000, "R3");

        // random phase with sticky requests
        begin
            logic [N-1:0] r;
            logic [N-1:0] l;
            logic         m;
            r = '0; m = 1'b0;
            for (int c = 0; c < 4000; c++) begin
                for (int i = 0; i < N; i++)
                    if ($urandom_range(0, 5) == 0) r[i] = ~r[i];
                l = '0;
                for (int i = 0; i < N; i++)
                    if ($urandom_range(0, 4) == 0) l[i] = 1'b1;
                if ($urandom_range(0, 19) == 0) m = ~m;
                step(r, l, m, expect_next(exp_g, r, l, m), tag_of(exp_g, r, l, m));
            end
        end

        // R1: reset in the middle of a transfer
        @(negedge clk); req = 4'b0001; lst = '0; rst = 1'b1;
        @(posedge clk); #1; check(4'b0000, "R1");
        @(negedge clk); rst = 1'b0; req = '0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule